// File: doc/BRIEF.md
# Float to Signed Integer Truncating Converter

This block turns one unpacked floating-point operand into a signed two's-complement integer. The integer is `INT_W` bits wide, 32 or 64. The operand arrives already split into fields:

- a 3-bit class code;
- a sign bit;
- a signed unbiased exponent;
- a mantissa whose top bit is the explicit leading one;
- a sticky bit that stands for nonzero bits lying below the mantissa.

The block always truncates toward zero. No rounding-mode input exists. It raises an inexact flag when fraction bits are thrown away, and an invalid flag when the value cannot be represented.

Out-of-range values and non-numbers saturate asymmetrically:

- a positive sign gives the largest positive integer;
- a negative sign gives the most negative integer.

When invalid is raised, inexact is always cleared. A request is a single-cycle pulse on `req_i`. The result, the flags and a one-cycle valid strobe appear on registered outputs on the following clock edge. The outputs hold their values between requests.

Top module: `fti_conv`

## Requirements
- R1: An operand of class code 0 (zero) gives result 0 with both flags clear, whatever its sign, exponent, mantissa or sticky bit.
- R2: Class codes are: 0 zero, 1 finite number, 2 infinity, 3 quiet NaN, 4 signalling NaN; codes 5 to 7 are also non-numbers. Every non-number gives invalid=1, inexact=0 and the saturated value of R8.
- R3: A finite number whose exponent is at least `INT_W` overflows, even if its fraction is nonzero.
- R4: A finite number has the value mant * 2^(exp - (MANT_W-1)), with mantissa bit MANT_W-1 as the leading one. The magnitude of the result is the integer part of that value, truncated toward zero. Any negative exponent gives magnitude 0.
- R5: When there is no overflow, inexact is 1 exactly when a discarded fraction bit is 1 or the sticky input is 1.
- R6: For a finite number with a set sign and no overflow, the result is the two's-complement negation of the magnitude. A magnitude of 0 gives 0.
- R7: Overflow also occurs when the magnitude is at least 2^(INT_W-1) + sign. So 2^(INT_W-1) is legal only for a negative operand, and a positive operand never yields a set top bit.
- R8: On overflow, invalid=1 and inexact=0. The result is 2^(INT_W-1)-1 for sign 0 and -2^(INT_W-1) for sign 1.
- R9: The result and flags appear on the clock edge after the one that samples `req_i`=1, and `vld_o` is high for that one cycle. With `req_i`=0, `vld_o` goes low on the next edge and the result and both flags keep their values.
- R10: While reset is active, `vld_o`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Convert the operand presented this cycle |
| cls_i | input | 3 | Operand class code |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Signed unbiased exponent |
| mant_i | input | MANT_W | Mantissa, leading one in the top bit |
| sticky_i | input | 1 | Nonzero bits lie below the mantissa |
| vld_o | output | 1 | Result strobe, one cycle per request |
| res_o | output | INT_W | Signed integer result |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Overflow or non-number operand |

## Verification
The bench builds two copies of the block from one stimulus stream. Both have a 53-bit mantissa and a 13-bit exponent; one has `INT_W`=32 and the other `INT_W`=64. The same operand can therefore sit right at the 32-bit saturation edge and well inside the 64-bit range. This places ±2^31, ±(2^31-1), -(2^31+0.5) and ±2^63 on both sides of the limit in one run. The 13-bit exponent also reaches large negative exponents and exponents above 64.

// File: rtl/fti_pkg.sv
package fti_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fcls_e;
endpackage

// File: rtl/fti_class.sv
module fti_class (
    input  logic [2:0] cls_i,
    output logic       is_zero_o,
    output logic       is_num_o,
    output logic       is_bad_o
);
    always_comb begin
        is_zero_o = (cls_i == fti_pkg::CLS_ZERO);
        is_num_o  = (cls_i == fti_pkg::CLS_NUM);
        // every other code, including unused ones, is a non-number
        is_bad_o  = !is_zero_o && !is_num_o;
    end
endmodule

// File: rtl/fti_align.sv
module fti_align #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 53,
    parameter int EXP_W  = 13
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  logic                    sticky_i,
    output logic [INT_W-1:0]        mag_o,
    output logic                    lost_o,
    output logic                    exp_big_o
);
    localparam int WIDE_W = INT_W + MANT_W;
    localparam int SH_W   = $clog2(INT_W + 1);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

    logic              exp_neg;
    logic [SH_W-1:0]   shamt;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        exp_neg   = exp_i[EXP_W-1];
        exp_big_o = (exp_i >= EXP_LIM);
        shamt     = '0;
        wide      = '0;
        mag_o     = '0;
        lost_o    = sticky_i;
        if (exp_neg) begin
            // whole mantissa is fraction
            lost_o = (|mant_i) | sticky_i;
        end else if (!exp_big_o) begin
            // leading one lands on integer bit 'exp'
            shamt  = SH_W'(exp_i[SH_W-1:0]) + SH_W'(1);
            wide   = {{INT_W{1'b0}}, mant_i} << shamt;
            mag_o  = wide[WIDE_W-1:MANT_W];
            lost_o = (|wide[MANT_W-1:0]) | sticky_i;
        end
    end
endmodule

// File: rtl/fti_limit.sv
module fti_limit #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] mag_i,
    input  logic             sign_i,
    input  logic             force_i,
    output logic             ovf_o,
    output logic [INT_W-1:0] value_o
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

    always_comb begin
        ovf_o = force_i || (mag_i > HALF) || ((mag_i == HALF) && !sign_i);
        if (ovf_o) begin
            value_o = sign_i ? HALF : ~HALF;
        end else begin
            value_o = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
        end
    end
endmodule

// File: rtl/fti_conv.sv
module fti_conv #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 53,
    parameter int EXP_W  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [2:0]              cls_i,
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  logic                    sticky_i,
    output logic                    vld_o,
    output logic [INT_W-1:0]        res_o,
    output logic                    inexact_o,
    output logic                    invalid_o
);
    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             nx;
        logic             nv;
    } state_t;

    state_t st_d, st_q;

    logic             is_zero, is_num, is_bad;
    logic [INT_W-1:0] mag;
    logic             lost, exp_big;
    logic             ovf;
    logic [INT_W-1:0] value;

    fti_class u_class (
        .cls_i     (cls_i),
        .is_zero_o (is_zero),
        .is_num_o  (is_num),
        .is_bad_o  (is_bad)
    );

    fti_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .exp_i     (exp_i),
        .mant_i    (mant_i),
        .sticky_i  (sticky_i),
        .mag_o     (mag),
        .lost_o    (lost),
        .exp_big_o (exp_big)
    );

    fti_limit #(.INT_W(INT_W)) u_limit (
        .mag_i   (mag),
        .sign_i  (sign_i),
        .force_i (is_bad || (is_num && exp_big)),
        .ovf_o   (ovf),
        .value_o (value)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_i;
        if (req_i) begin
            if (is_zero) begin
                st_d.res = '0;
                st_d.nx  = 1'b0;
                st_d.nv  = 1'b0;
            end else begin
                st_d.res = value;
                st_d.nv  = ovf;
                // invalid displaces inexact
                st_d.nx  = lost && !ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o     = st_q.vld;
    assign res_o     = st_q.res;
    assign inexact_o = st_q.nx;
    assign invalid_o = st_q.nv;
endmodule

// File: rtl/fti_conv_chk.sv
module fti_conv_chk #(
    parameter int INT_W = 32,
    parameter int EXP_W = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_i,
    input logic [2:0]              cls_i,
    input logic                    sign_i,
    input logic signed [EXP_W-1:0] exp_i,
    input logic                    vld_o,
    input logic [INT_W-1:0]        res_o,
    input logic                    inexact_o,
    input logic                    invalid_o
);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);
    localparam logic [INT_W-1:0] MINV = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] MAXV = ~MINV;

    AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o); // R9
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !vld_o); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(res_o) && $stable(inexact_o) && $stable(invalid_o))); // R9
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == fti_pkg::CLS_ZERO) |=> (res_o == '0 && !inexact_o && !invalid_o)); // R1
    AST_NONNUM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i != fti_pkg::CLS_ZERO && cls_i != fti_pkg::CLS_NUM) |=> invalid_o); // R2
    AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == fti_pkg::CLS_NUM && exp_i >= EXP_LIM) |=> invalid_o); // R3
    AST_POS_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == fti_pkg::CLS_NUM && !sign_i) |=> !res_o[INT_W-1]); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(inexact_o && invalid_o)); // R8
    AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (!invalid_o || res_o == ($past(sign_i) ? MINV : MAXV))); // R8
endmodule

bind fti_conv fti_conv_chk #(.INT_W(INT_W), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cls_i     (cls_i),
    .sign_i    (sign_i),
    .exp_i     (exp_i),
    .vld_o     (vld_o),
    .res_o     (res_o),
    .inexact_o (inexact_o),
    .invalid_o (invalid_o)
);

// File: tb/fti_conv_bench.sv
`timescale 1ns/1ps
module fti_conv_bench;
    localparam int MW = 53;
    localparam int EW = 13;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req = 1'b0;
    logic [2:0]           cls = 3'd0;
    logic                 sgn = 1'b0;
    logic signed [EW-1:0] ex = '0;
    logic [MW-1:0]        mant = '0;
    logic                 stk = 1'b0;

    logic        v32, nx32, nv32, v64, nx64, nv64;
    logic [31:0] r32;
    logic [63:0] r64;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    fti_conv #(.INT_W(32), .MANT_W(MW), .EXP_W(EW)) u_fti_conv (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cls_i(cls), .sign_i(sgn),
        .exp_i(ex), .mant_i(mant), .sticky_i(stk),
        .vld_o(v32), .res_o(r32), .inexact_o(nx32), .invalid_o(nv32));

    fti_conv #(.INT_W(64), .MANT_W(MW), .EXP_W(EW)) u_fti_conv_w64 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cls_i(cls), .sign_i(sgn),
        .exp_i(ex), .mant_i(mant), .sticky_i(stk),
        .vld_o(v64), .res_o(r64), .inexact_o(nx64), .invalid_o(nv64));

    // place bit 'top' of k at the leading-one position
    function automatic logic [MW-1:0] mk(input logic [63:0] k, input int top);
        if (top <= MW - 1) return MW'(k << (MW - 1 - top));
        else return MW'(k >> (top - (MW - 1)));
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] want,
                         input logic gnx, input logic wnx, input logic gnv, input logic wnv);
        n_tests++;
        if (got !== want || gnx !== wnx || gnv !== wnv) begin
            n_fail++;
            $display("FAIL %s: got %h nx=%0b nv=%0b expected %h nx=%0b nv=%0b",
                     tag, got, gnx, gnv, want, wnx, wnv);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic s, input int e,
                         input logic [MW-1:0] m, input logic st);
        @(negedge clk);
        cls = c; sgn = s; ex = EW'(e); mant = m; stk = st; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic both(input string tag, input logic [31:0] w32, input logic x32, input logic i32,
                        input logic [63:0] w64, input logic x64, input logic i64);
        check({tag, " w32"}, {32'b0, r32}, {32'b0, w32}, nx32, x32, nv32, i32);
        check({tag, " w64"}, r64, w64, nx64, x64, nv64, i64);
        check({tag, " R9 strobe"}, {62'b0, v32, v64}, 64'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        check("R10 reset w32", {32'b0, r32}, 64'd0, nx32 | v32, 1'b0, nv32, 1'b0);
        check("R10 reset w64", r64, 64'd0, nx64 | v64, 1'b0, nv64, 1'b0);
    endtask

    task automatic t_zero();
        drive(3'd0, 1'b1, 5, mk(3, 1), 1'b1);
        both("R1 zero class", 32'd0, 0, 0, 64'd0, 0, 0);
    endtask

    task automatic t_plain();
        drive(3'd1, 1'b0, 2, mk(5, 2), 1'b0);
        both("R4 +5.0", 32'd5, 0, 0, 64'd5, 0, 0);
        drive(3'd1, 1'b1, 2, mk(5, 2), 1'b0);
        both("R6 -5.0", 32'hfffffffb, 0, 0, 64'hfffffffffffffffb, 0, 0);
    endtask

    task automatic t_frac();
        drive(3'd1, 1'b1, 2, mk(23, 4), 1'b0);
        both("R5 -5.75", 32'hfffffffb, 1, 0, 64'hfffffffffffffffb, 1, 0);
        drive(3'd1, 1'b0, -1, mk(1, 0), 1'b0);
        both("R4 +0.5", 32'd0, 1, 0, 64'd0, 1, 0);
        drive(3'd1, 1'b1, -1, mk(3, 1), 1'b0);
        both("R6 -0.75", 32'd0, 1, 0, 64'd0, 1, 0);
        drive(3'd1, 1'b1, -2000, mk(1, 0), 1'b0);
        both("R4 tiny", 32'd0, 1, 0, 64'd0, 1, 0);
        drive(3'd1, 1'b0, 1, mk(3, 1), 1'b1);
        both("R5 sticky only", 32'd3, 1, 0, 64'd3, 1, 0);
    endtask

    task automatic t_bound();
        drive(3'd1, 1'b0, 31, mk(1, 0), 1'b0);
        both("R7 +2^31", 32'h7fffffff, 0, 1, 64'h80000000, 0, 0);
        drive(3'd1, 1'b1, 31, mk(1, 0), 1'b0);
        both("R7 -2^31", 32'h80000000, 0, 0, 64'hffffffff80000000, 0, 0);
        drive(3'd1, 1'b0, 30, mk(64'h7fffffff, 30), 1'b0);
        both("R4 +(2^31-1)", 32'h7fffffff, 0, 0, 64'h7fffffff, 0, 0);
        drive(3'd1, 1'b1, 30, mk(64'h7fffffff, 30), 1'b0);
        both("R6 -(2^31-1)", 32'h80000001, 0, 0, 64'hffffffff80000001, 0, 0);
        drive(3'd1, 1'b1, 31, mk(64'h100000001, 32), 1'b0);
        both("R7 -(2^31+0.5)", 32'h80000000, 1, 0, 64'hffffffff80000000, 1, 0);
        drive(3'd1, 1'b1, 31, mk(64'h80000001, 31), 1'b0);
        both("R7 -(2^31+1)", 32'h80000000, 0, 1, 64'hffffffff7fffffff, 0, 0);
        drive(3'd1, 1'b0, 31, mk(64'h100000001, 32), 1'b0);
        both("R8 +(2^31+0.5)", 32'h7fffffff, 0, 1, 64'h80000000, 1, 0);
        drive(3'd1, 1'b0, 63, mk(1, 0), 1'b0);
        both("R7 +2^63", 32'h7fffffff, 0, 1, 64'h7fffffffffffffff, 0, 1);
        drive(3'd1, 1'b1, 63, mk(1, 0), 1'b0);
        both("R7 -2^63", 32'h80000000, 0, 1, 64'h8000000000000000, 0, 0);
        drive(3'd1, 1'b1, 64, mk(1, 0), 1'b1);
        both("R3 exp 64", 32'h80000000, 0, 1, 64'h8000000000000000, 0, 1);
        drive(3'd1, 1'b0, 40, mk(3, 1), 1'b1);
        both("R3 1.5*2^40", 32'h7fffffff, 0, 1, 64'h18000000000, 1, 0);
    endtask

    task automatic t_nonnum();
        logic [2:0] codes [4] = '{3'd2, 3'd3, 3'd4, 3'd7};
        for (int i = 0; i < 4; i++) begin
            for (int s = 0; s < 2; s++) begin
                drive(codes[i], s[0], 3, mk(1, 0), 1'b1);
                if (s == 0)
                    both($sformatf("R2 class %0d pos", codes[i]), 32'h7fffffff, 0, 1,
                         64'h7fffffffffffffff, 0, 1);
                else
                    both($sformatf("R2 class %0d neg", codes[i]), 32'h80000000, 0, 1,
                         64'h8000000000000000, 0, 1);
            end
        end
    endtask

    task automatic t_hold();
        drive(3'd1, 1'b1, 2, mk(23, 4), 1'b0);
        @(negedge clk);
        cls = 3'd2; sgn = 1'b0; ex = EW'(70); mant = mk(1, 0); stk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold w32", {32'b0, r32}, 64'hfffffffb, nx32, 1'b1, nv32, 1'b0);
        check("R9 hold w64", r64, 64'hfffffffffffffffb, nx64, 1'b1, nv64, 1'b0);
        check("R9 strobe low", {62'b0, v32, v64}, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_zero();
        t_plain();
        t_frac();
        t_bound();
        t_nonnum();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule